// File: doc/BRIEF.md
# Conversion Run Sequencer

This block is the control state machine in front of a converter's decimation filter. It decides when the conversion engine runs and when it restarts, and it drives the active-low data-ready line seen by the host. A start can come from a level pin (on its rising edge) or from a one-cycle start command strobe. A stop can come from the pin's falling edge or from a stop command strobe. Command strobes only take effect while the pin is low.

After each start, the filter needs a fixed number of conversions before its output is valid. The sequencer therefore throws away the first `SETTLE_CONVS - 1` completion strobes. As a result, the distance from a start to the first data-ready depends only on the conversion period, so several devices started together report together.

In continuous mode, conversions repeat until a stop request. The stop lets the conversion in flight finish. In single-shot mode, each start yields one valid result. Data-ready then stays asserted, whether or not the data is read, until the next start.

Top module: `conv_seq`

## Requirements
- R1: While `rst` is high and in the cycle after it, `conv_run` = 0, `conv_restart` = 0 and `drdy_n` = 1.
- R2: A rising edge on `start_pin` sets `conv_run` = 1, `conv_restart` = 1 and `drdy_n` = 1 in the next cycle. `conv_restart` lasts exactly one cycle.
- R3: `cmd_start` starts conversions (same outputs as R2) only when `start_pin` is low in that cycle. While `start_pin` is high, `cmd_start` and `cmd_stop` are ignored.
- R4: After a start, the first `SETTLE_CONVS - 1` `conv_done` strobes leave `drdy_n` high. The next one drives `drdy_n` to 0 in the following cycle (default `SETTLE_CONVS` = 3).
- R5: In continuous mode (`single_shot` = 0 at the start event), every later `conv_done` drives `drdy_n` low, and `data_read` drives it back high in the next cycle. A `conv_done` in the same cycle as `data_read` wins.
- R6: A stop request (falling edge of `start_pin`, or `cmd_stop` with the pin low) keeps `conv_run` at 1 until the next `conv_done`. `conv_run` drops in the cycle after that strobe. That strobe still produces data if the filter has settled.
- R7: A stop request while `conv_run` = 0 changes no output.
- R8: In single-shot mode (`single_shot` = 1 at the start event), the settled `conv_done` drives `drdy_n` low and `conv_run` low together. `drdy_n` then stays low, ignoring `data_read`, until the next start event.
- R9: A start event while running pulses `conv_restart`, sets `drdy_n` = 1, restarts the settling count and cancels a pending stop.
- R10: `conv_done` while `conv_run` = 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_pin | input | 1 | Level start control; rising edge starts, falling edge stops |
| cmd_start | input | 1 | One-cycle start command strobe |
| cmd_stop | input | 1 | One-cycle stop command strobe |
| single_shot | input | 1 | Mode select, captured at each start event (1 = single-shot) |
| conv_done | input | 1 | Conversion-complete strobe from the engine |
| data_read | input | 1 | Strobe marking that the host began reading the result |
| conv_run | output | 1 | Conversion engine enable |
| conv_restart | output | 1 | One-cycle filter/engine restart pulse |
| drdy_n | output | 1 | Data ready, active low |

## Verification
Directed sequences cover the following cases:
- pin-driven and command-driven starts, which separate the two start sources and the pin-high masking of commands;
- stop requests made during settling and after settling, which show whether the final conversion is drained and whether it yields data;
- single-shot runs followed by reads, which separate the sticky data-ready from the continuous-mode clear;
- starts issued mid-settling and while a stop is pending, which expose a settle count or stop flag that is not reset.

A seeded random phase then mixes pin toggles, command strobes, mode changes, completions and reads at varied rates. A bench reference model derived from the requirements checks it every cycle, which catches priority errors when events coincide.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_RUN   = 2'd1,
        SEQ_DRAIN = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic start;
        logic stop;
    } seq_evt_t;

    function automatic int unsigned cnt_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/conv_seq_evt.sv
module conv_seq_evt
    import conv_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start_pin,
    input  logic     cmd_start,
    input  logic     cmd_stop,
    output seq_evt_t evt
);
    logic pin_q;

    always_ff @(posedge clk) begin
        if (rst) pin_q <= 1'b0;
        else     pin_q <= start_pin;
    end

    // Commands are masked while the pin holds control.
    always_comb begin
        evt.start = (start_pin & ~pin_q) | (cmd_start & ~start_pin);
        evt.stop  = (~start_pin & pin_q) | (cmd_stop & ~start_pin);
    end
endmodule

// File: rtl/conv_seq_settle.sv
module conv_seq_settle
    import conv_seq_pkg::*;
#(
    parameter int unsigned SETTLE_CONVS = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic step,
    output logic settled
);
    localparam int unsigned CW = cnt_width(SETTLE_CONVS);
    localparam logic [CW-1:0] LAST = CW'(SETTLE_CONVS - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear)              cnt_q <= '0;
        else if (step && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
    end

    assign settled = (cnt_q == LAST);
endmodule

// File: rtl/conv_seq_ctrl.sv
module conv_seq_ctrl
    import conv_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  seq_evt_t evt,
    input  logic     single_shot,
    input  logic     conv_done,
    input  logic     data_read,
    input  logic     settled,
    output logic     conv_run,
    output logic     conv_restart,
    output logic     drdy_n
);
    seq_state_e state_q;
    logic       ss_q;
    logic       restart_q;
    logic       drdy_q;
    logic       active;
    logic       data_ev;
    logic       finish;

    always_comb begin
        active  = (state_q != SEQ_IDLE);
        data_ev = conv_done & active & settled & ~evt.start;
        finish  = conv_done & active & ~evt.start &
                  ((state_q == SEQ_DRAIN) | evt.stop | (data_ev & ss_q));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= SEQ_IDLE;
            ss_q      <= 1'b0;
            restart_q <= 1'b0;
            drdy_q    <= 1'b1;
        end else begin
            restart_q <= evt.start;
            if (evt.start) begin
                state_q <= SEQ_RUN;
                ss_q    <= single_shot;
                drdy_q  <= 1'b1;
            end else begin
                if (finish)
                    state_q <= SEQ_IDLE;
                else if (evt.stop && state_q == SEQ_RUN)
                    state_q <= SEQ_DRAIN;

                if (data_ev)
                    drdy_q <= 1'b0;
                else if (data_read && !ss_q)
                    drdy_q <= 1'b1;
            end
        end
    end

    assign conv_run     = active;
    assign conv_restart = restart_q;
    assign drdy_n       = drdy_q;
endmodule

// File: rtl/conv_seq.sv
module conv_seq
    import conv_seq_pkg::*;
#(
    parameter int unsigned SETTLE_CONVS = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic start_pin,
    input  logic cmd_start,
    input  logic cmd_stop,
    input  logic single_shot,
    input  logic conv_done,
    input  logic data_read,
    output logic conv_run,
    output logic conv_restart,
    output logic drdy_n
);
    seq_evt_t evt;
    logic     settled;
    logic     run_w;

    conv_seq_evt u_evt (
        .clk       (clk),
        .rst       (rst),
        .start_pin (start_pin),
        .cmd_start (cmd_start),
        .cmd_stop  (cmd_stop),
        .evt       (evt)
    );

    conv_seq_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .evt          (evt),
        .single_shot  (single_shot),
        .conv_done    (conv_done),
        .data_read    (data_read),
        .settled      (settled),
        .conv_run     (run_w),
        .conv_restart (conv_restart),
        .drdy_n       (drdy_n)
    );

    conv_seq_settle #(.SETTLE_CONVS(SETTLE_CONVS)) u_settle (
        .clk     (clk),
        .rst     (rst),
        .clear   (evt.start),
        .step    (conv_done & run_w),
        .settled (settled)
    );

    assign conv_run = run_w;
endmodule

// File: rtl/conv_seq_chk.sv
module conv_seq_chk (
    input logic clk,
    input logic rst,
    input logic start_pin,
    input logic cmd_start,
    input logic conv_done,
    input logic data_read,
    input logic conv_run,
    input logic conv_restart,
    input logic drdy_n
);
    // R2
    pin_rise_restart_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(start_pin) |=> (conv_restart && conv_run));

    // R3
    cmd_masked_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && start_pin && $past(start_pin) && !conv_run && cmd_start) |=> !conv_run);

    // R4
    drdy_fall_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(drdy_n) |-> $past(conv_done));

    // R5
    drdy_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(drdy_n) |-> ($past(data_read) || conv_restart));

    // R6
    run_drop_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(conv_run) |-> $past(conv_done));

    // R10
    idle_done_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (!conv_run && conv_done && !cmd_start && !start_pin && !data_read) |=> $stable(drdy_n));
endmodule

bind conv_seq conv_seq_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .start_pin    (start_pin),
    .cmd_start    (cmd_start),
    .conv_done    (conv_done),
    .data_read    (data_read),
    .conv_run     (conv_run),
    .conv_restart (conv_restart),
    .drdy_n       (drdy_n)
);

// File: tb/conv_seq_tb_top.sv
`timescale 1ns/1ps
module conv_seq_tb_top;
    localparam int SC = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_pin = 0, cmd_start = 0, cmd_stop = 0, single_shot = 0;
    logic conv_done = 0, data_read = 0;
    logic conv_run, conv_restart, drdy_n;

    int checks = 0;
    int fails  = 0;
    bit done_flag = 0;

    // reference model state
    bit m_act, m_drain, m_ss, m_run, m_rs, m_drdy, m_pinq;
    int m_cnt;

    always #2 clk = ~clk;

    conv_seq #(.SETTLE_CONVS(SC)) dut_i (
        .clk(clk), .rst(rst), .start_pin(start_pin), .cmd_start(cmd_start),
        .cmd_stop(cmd_stop), .single_shot(single_shot), .conv_done(conv_done),
        .data_read(data_read), .conv_run(conv_run), .conv_restart(conv_restart),
        .drdy_n(drdy_n)
    );

    task automatic model_reset();
        m_act = 0; m_drain = 0; m_ss = 0; m_run = 0; m_rs = 0; m_drdy = 1;
        m_pinq = 0; m_cnt = 0;
    endtask

    task automatic model_step();
        bit st, sp, dev, fin;
        st  = (start_pin && !m_pinq) || (cmd_start && !start_pin);
        sp  = (!start_pin && m_pinq) || (cmd_stop && !start_pin);
        dev = conv_done && m_act && (m_cnt == SC - 1) && !st;
        fin = conv_done && m_act && !st && (m_drain || sp || (dev && m_ss));
        m_rs = st;
        if (st) begin
            m_act = 1; m_drain = 0; m_ss = single_shot; m_cnt = 0; m_drdy = 1;
        end else begin
            if (conv_done && m_act && m_cnt < SC - 1) m_cnt++;
            if (dev) m_drdy = 0;
            else if (data_read && !m_ss) m_drdy = 1;
            if (fin) begin
                m_act = 0; m_drain = 0;
            end else if (sp && m_act) m_drain = 1;
        end
        m_run  = m_act;
        m_pinq = start_pin;
    endtask

    task automatic cyc(input logic p, input logic a, input logic b,
                       input logic s, input logic d, input logic r);
        start_pin = p; cmd_start = a; cmd_stop = b; single_shot = s;
        conv_done = d; data_read = r;
        @(posedge clk);
        if (rst) model_reset(); else model_step();
        @(negedge clk);
        start_pin = p; cmd_start = 0; cmd_stop = 0; conv_done = 0; data_read = 0;
    endtask

    task automatic chk(input string req, input logic run_e, input logic rs_e,
                       input logic dr_e);
        checks++;
        if (conv_run !== run_e || conv_restart !== rs_e || drdy_n !== dr_e) begin
            fails++;
            $display("FAIL %s: run/restart/drdy_n actual=%b%b%b expected=%b%b%b",
                     req, conv_run, conv_restart, drdy_n, run_e, rs_e, dr_e);
        end
    endtask

    task automatic do_reset();
        rst = 1;
        cyc(0, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0);
        rst = 0;
        model_reset();
    endtask

    function automatic bit pick(input int unsigned den);
        return ($urandom % den) == 0;
    endfunction

    initial begin
        bit p, s;
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset();
        chk("R1 reset", 0, 0, 1);

        // pin start
        cyc(1, 0, 0, 0, 0, 0); chk("R2 pin rise", 1, 1, 1);
        cyc(1, 0, 0, 0, 0, 0); chk("R2 restart one cycle", 1, 0, 1);
        cyc(1, 0, 1, 0, 0, 0); chk("R3 stop cmd masked by pin", 1, 0, 1);
        cyc(1, 0, 0, 0, 1, 0); chk("R4 settle done 1", 1, 0, 1);
        cyc(1, 0, 0, 0, 1, 0); chk("R4 settle done 2", 1, 0, 1);
        cyc(1, 0, 0, 0, 1, 0); chk("R4 first data", 1, 0, 0);
        cyc(1, 0, 0, 0, 0, 1); chk("R5 read clears", 1, 0, 1);
        cyc(1, 0, 0, 0, 1, 0); chk("R5 next data", 1, 0, 0);
        cyc(1, 0, 0, 0, 1, 1); chk("R5 done wins over read", 1, 0, 0);
        cyc(1, 0, 0, 0, 0, 1); chk("R5 read clears again", 1, 0, 1);

        // stop drains
        cyc(0, 0, 0, 0, 0, 0); chk("R6 pin fall keeps run", 1, 0, 1);
        cyc(0, 0, 0, 0, 0, 0); chk("R6 still draining", 1, 0, 1);
        cyc(0, 0, 0, 0, 1, 0); chk("R6 final conv gives data", 0, 0, 0);
        cyc(0, 0, 1, 0, 0, 0); chk("R7 stop while idle", 0, 0, 0);
        cyc(0, 0, 0, 0, 1, 0); chk("R10 done while idle", 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 1); chk("R5 read after stop", 0, 0, 1);

        // single shot
        cyc(0, 1, 0, 1, 0, 0); chk("R3 cmd start", 1, 1, 1);
        cyc(0, 0, 0, 0, 1, 0); chk("R8 settle 1", 1, 0, 1);
        cyc(0, 0, 0, 0, 1, 0); chk("R8 settle 2", 1, 0, 1);
        cyc(0, 0, 0, 0, 1, 0); chk("R8 one result then halt", 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 1); chk("R8 read ignored", 0, 0, 0);
        cyc(0, 0, 0, 0, 1, 1); chk("R8 stays low", 0, 0, 0);
        cyc(0, 1, 0, 1, 0, 0); chk("R8 cleared by next start", 1, 1, 1);

        // restart mid-settle
        cyc(0, 0, 0, 1, 1, 0); chk("R9 pre-restart done", 1, 0, 1);
        cyc(0, 1, 0, 1, 0, 0); chk("R9 restart pulse", 1, 1, 1);
        cyc(0, 0, 0, 1, 1, 0); chk("R9 settle recount 1", 1, 0, 1);
        cyc(0, 0, 0, 1, 1, 0); chk("R9 settle recount 2", 1, 0, 1);
        cyc(0, 0, 0, 1, 1, 0); chk("R9 data after recount", 0, 0, 0);

        // restart cancels pending stop
        cyc(0, 1, 0, 0, 0, 0); chk("R9 start continuous", 1, 1, 1);
        cyc(0, 0, 1, 0, 0, 0); chk("R6 cmd stop pending", 1, 0, 1);
        cyc(0, 1, 0, 0, 0, 0); chk("R9 start over pending stop", 1, 1, 1);
        cyc(0, 0, 0, 0, 1, 0); chk("R9 stop cancelled", 1, 0, 1);

        // random phase against reference model
        do_reset();
        chk("R1 reset again", 0, 0, 1);
        p = 0; s = 0;
        for (int i = 0; i < 4000; i++) begin
            if (pick(24)) p = ~p;
            if (pick(40)) s = ~s;
            cyc(p, pick(18), pick(14), s, pick(3), pick(5));
            chk("R2/R4/R5/R6/R8/R9 random", m_run, m_rs, m_drdy);
        end

        done_flag = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #400000;
        if (!done_flag) begin
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule